// File: doc/BRIEF.md
# Shared-Line Serial EEPROM Read Controller

This block is the master side of a word read from a small three-wire serial EEPROM. On that part the data input and the data output are tied together into one bidirectional line. The controller raises chip select and generates the serial clock from the system clock. It drives the start bit, the read opcode and a 6-bit address onto the shared line through an external buffer whose enable is active low. It then hands the line over to the memory and collects a 16-bit word.

The memory starts driving the line on the same rising serial-clock edge that samples the last address bit. The controller therefore keeps its buffer enabled for a programmable hold window after that edge, and then releases it before the next falling edge. The first bit the memory returns is a dummy zero, which is discarded. The user side is a start strobe with an address, a busy level, a one-cycle done pulse and a registered read word.

Top module: `mw_read_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the next cycle shows `cs_o`=0, `sk_o`=0, `dq_oe_n_o`=1, `busy_o`=0, `done_o`=0 and `rdata_o`=0. This also holds when reset arrives in the middle of a frame.
- R2: `sk_o` is high only while `cs_o` is high. Each serial period is DIV system cycles long, with `sk_o` low for the first DIV/2 cycles and high for the rest, counted from the cycle after the start is accepted.
- R3: With the buffer enabled, `dq_o` carries nine bits in this order, one per serial period: 1 (start), 1, 0 (read opcode), then address bits 5 down to 0. Each bit stays stable across its rising `sk_o` edge.
- R4: `dq_oe_n_o` goes low together with `cs_o`. It returns high exactly HOLD_CYC system cycles after the ninth rising `sk_o` edge (the one that samples address bit 0), which is before the next falling edge. It stays high until the next frame.
- R5: The sample taken at rising edge 10 is discarded. The samples at rising edges 11 to 26 form the word, first bit at bit 15. That word appears on `rdata_o` together with `done_o` and is held until the next completion.
- R6: Every frame has exactly 26 rising `sk_o` edges. `cs_o` rises in the cycle after the start is accepted and falls with the falling `sk_o` edge that ends the 26th serial period.
- R7: DIV cycles after `cs_o` falls, `done_o` is high for exactly one cycle and `busy_o` drops in that same cycle. In that cycle the controller is idle and accepts a new start.
- R8: A start request made while `busy_o` is high is ignored. No new frame begins, and the word returned is the one for the address accepted first.
- R9: The address is captured in the cycle the start is accepted. Changes on `addr_i` after that have no effect on the frame.
- R10: `busy_o` rises in the same cycle as `cs_o` after an accepted start and stays high until `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a word read; accepted when idle |
| addr_i | input | 6 | Word address, captured on acceptance |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last word read |
| cs_o | output | 1 | Chip select to the memory, active high |
| sk_o | output | 1 | Serial clock to the memory |
| dq_o | output | 1 | Data for the external line buffer |
| dq_oe_n_o | output | 1 | Line buffer enable, active low |
| dq_i | input | 1 | Level observed on the shared data line |

## Verification
The assertions assume that the reset is held low for at least one clock edge before any start, and that DIV is at least 4 so that every serial-clock level lasts two or more system cycles. They also assume that `dq_i` reflects the memory's output only through the line, never as a combinational function of `dq_o` while the memory drives. The bench keeps within this. It holds reset for several cycles, drives all inputs on the falling clock edge, and uses a memory model that updates its output only after it sees a rising serial-clock edge. During overlap the model lets the master's level win on the line, and elsewhere the line is pulled high.

// File: rtl/mw_pkg.sv
// Package mw_pkg
// Shared types and frame constants for the shared-line serial EEPROM read
// controller. Assumes a read frame of start bit, two opcode bits and address.
package mw_pkg;

    // Controller phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } mw_state_t;

    // Start bit followed by the read opcode, sent most significant first
    localparam int unsigned  MW_HDR_W = 3;
    localparam logic [2:0]   MW_RD_HDR = 3'b110;

endpackage

// File: rtl/mw_sclk_gen.sv
// Module mw_sclk_gen
// Divides the system clock into the serial clock while run is high.
// Each serial period is DIV cycles: low for DIV/2 cycles, then high.
// Emits one-cycle rise/fall event strobes in the cycle before sk changes.
// Assumes DIV >= 4; the phase counter restarts at zero whenever run is low.
module mw_sclk_gen #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] ph_q;

    // Event strobes decoded from the phase counter
    assign rise_evt = run && (ph_q == PH_RISE);
    assign fall_evt = run && (ph_q == PH_LAST);

    // Phase counter: wraps every DIV cycles, held at zero when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q <= '0;
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Serial clock level register
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sk <= 1'b0;
        end else if (rise_evt) begin
            sk <= 1'b1;
        end else if (fall_evt) begin
            sk <= 1'b0;
        end
    end

endmodule

// File: rtl/mw_frame_shift.sv
// Module mw_frame_shift
// Holds the outgoing header+address frame and the incoming data word.
// load captures the frame; shift_tx advances to the next outgoing bit;
// shift_rx appends rx_bit at the least significant end.
// Assumes the controller never asserts load together with a shift.
module mw_frame_shift
    import mw_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic              shift_tx,
    input  logic              shift_rx,
    input  logic              rx_bit,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_word
);
    localparam int unsigned FRAME_W = MW_HDR_W + ADDR_W;

    logic [FRAME_W-1:0] tx_q;

    assign tx_bit = tx_q[FRAME_W-1];

    // Outgoing frame register, most significant bit on the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= {MW_RD_HDR, addr};
        end else if (shift_tx) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    // Incoming word register, first sampled bit ends up most significant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (shift_rx) begin
            rx_word <= {rx_word[DATA_W-2:0], rx_bit};
        end
    end

endmodule

// File: rtl/mw_read_seq.sv
// Module mw_read_seq
// Sequencer for one read frame: counts serial periods, owns chip select,
// the line buffer enable, the completion gap and the user handshake.
// Assumes rise_evt/fall_evt come from mw_sclk_gen running while run is high,
// and 1 <= HOLD_CYC < DIV/2 so the buffer is released inside the A0 period.
module mw_read_seq
    import mw_pkg::*;
#(
    parameter int unsigned DIV      = 8,
    parameter int unsigned HOLD_CYC = 2,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic [DATA_W-1:0] rx_word,
    output logic              run,
    output logic              load,
    output logic              shift_tx,
    output logic              shift_rx,
    output logic              cs,
    output logic              oe_n,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned FRAME_W = MW_HDR_W + ADDR_W;
    localparam int unsigned NBITS   = FRAME_W + 1 + DATA_W;
    localparam int unsigned BIT_W   = $clog2(NBITS);
    localparam int unsigned GAP_W   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned HOLD_W  = $clog2(HOLD_CYC + 1);

    localparam logic [BIT_W-1:0]  LAST_TX   = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0]  FIRST_RX  = BIT_W'(FRAME_W + 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(NBITS - 1);
    localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(DIV - 1);
    localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_CYC);
    localparam logic [HOLD_W-1:0] HOLD_ONE  = HOLD_W'(1);

    mw_state_t         state_q;
    logic [BIT_W-1:0]  bit_q;
    logic [GAP_W-1:0]  gap_q;
    logic [HOLD_W-1:0] hold_q;
    logic              in_xfer;
    logic              in_gap;
    logic              gap_end;

    assign in_xfer  = (state_q == ST_XFER);
    assign in_gap   = (state_q == ST_GAP);
    assign gap_end  = in_gap && (gap_q == GAP_LAST);
    assign run      = in_xfer;
    assign load     = (state_q == ST_IDLE) && start;
    assign shift_tx = in_xfer && fall_evt && (bit_q != LAST_TX) && (bit_q < LAST_TX);
    assign shift_rx = in_xfer && rise_evt && (bit_q >= FIRST_RX);

    // Phase sequencing: idle -> transfer -> chip-select gap -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_XFER;
                ST_XFER: if (fall_evt && (bit_q == LAST_BIT)) state_q <= ST_GAP;
                ST_GAP:  if (gap_end) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Serial period counter within the frame
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            bit_q <= '0;
        end else if (in_xfer && fall_evt && (bit_q != LAST_BIT)) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    // Chip select: high from acceptance to the end of the last serial period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs <= 1'b0;
        end else if (load) begin
            cs <= 1'b1;
        end else if (in_xfer && fall_evt && (bit_q == LAST_BIT)) begin
            cs <= 1'b0;
        end
    end

    // Hold window counter started by the rising edge that samples A0
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            hold_q <= '0;
        end else if (in_xfer && rise_evt && (bit_q == LAST_TX)) begin
            hold_q <= HOLD_INIT;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    // Line buffer enable: on with the frame, off when the hold window ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_n <= 1'b1;
        end else if (load) begin
            oe_n <= 1'b0;
        end else if ((hold_q == HOLD_ONE) || !cs) begin
            oe_n <= 1'b1;
        end
    end

    // Chip-select low gap counter
    always_ff @(posedge clk) begin
        if (!rst_n || !in_gap) begin
            gap_q <= '0;
        end else if (!gap_end) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // User handshake: busy level and one-cycle done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= gap_end;
            if (load) begin
                busy <= 1'b1;
            end else if (gap_end) begin
                busy <= 1'b0;
            end
        end
    end

    // Result register, updated only at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (gap_end) begin
            rdata <= rx_word;
        end
    end

endmodule

// File: rtl/mw_read_ctrl.sv
// Module mw_read_ctrl (top)
// Master-side word read controller for a serial EEPROM whose data in and
// data out share one line. Generates chip select and serial clock, drives the
// read frame through an external buffer with active-low enable, releases the
// buffer HOLD_CYC cycles after the A0 rising edge, skips the dummy zero and
// captures DATA_W bits. Assumes DIV >= 4 and 1 <= HOLD_CYC < DIV/2.
module mw_read_ctrl #(
    parameter int unsigned DIV      = 8,
    parameter int unsigned HOLD_CYC = 2,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              dq_o,
    output logic              dq_oe_n_o,
    input  logic              dq_i
);
    logic              run;
    logic              rise_evt;
    logic              fall_evt;
    logic              load;
    logic              shift_tx;
    logic              shift_rx;
    logic              tx_bit;
    logic [DATA_W-1:0] rx_word;

    mw_sclk_gen #(
        .DIV(DIV)
    ) sclk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sk      (sk_o),
        .rise_evt(rise_evt),
        .fall_evt(fall_evt)
    );

    mw_frame_shift #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr    (addr_i),
        .shift_tx(shift_tx),
        .shift_rx(shift_rx),
        .rx_bit  (dq_i),
        .tx_bit  (tx_bit),
        .rx_word (rx_word)
    );

    mw_read_seq #(
        .DIV     (DIV),
        .HOLD_CYC(HOLD_CYC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .rise_evt(rise_evt),
        .fall_evt(fall_evt),
        .rx_word (rx_word),
        .run     (run),
        .load    (load),
        .shift_tx(shift_tx),
        .shift_rx(shift_rx),
        .cs      (cs_o),
        .oe_n    (dq_oe_n_o),
        .busy    (busy_o),
        .done    (done_o),
        .rdata   (rdata_o)
    );

    // Data toward the buffer is forced low whenever the buffer is disabled
    assign dq_o = tx_bit & ~dq_oe_n_o;

endmodule

// File: rtl/mw_read_ctrl_chk.sv
// Module mw_read_ctrl_chk
// Protocol checker for mw_read_ctrl, attached by bind. Observes ports only.
module mw_read_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic cs_o,
    input logic sk_o,
    input logic dq_oe_n_o
);

    // R2
    sk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sk_o |-> cs_o);

    // R2
    sk_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sk_o) |=> sk_o);

    // R4
    drv_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_o |-> dq_oe_n_o);

    // R4
    drv_on_at_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe_n_o) |-> $rose(cs_o));

    // R6
    cs_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> ($past(start_i) && !$past(busy_o)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !cs_o));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !$rose(cs_o));

    // R10
    busy_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $rose(cs_o));

endmodule

bind mw_read_ctrl mw_read_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .cs_o     (cs_o),
    .sk_o     (sk_o),
    .dq_oe_n_o(dq_oe_n_o)
);

// File: tb/mw_read_ctrl_tb.sv
module mw_read_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int HALF       = DIV / 2;
    localparam int HOLD_CYC   = 2;
    localparam int T_CSLOW    = 26 * DIV;
    localparam int T_DONE     = 27 * DIV;
    localparam int T_REL      = 8 * DIV + HALF + HOLD_CYC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic        busy_o, done_o, cs_o, sk_o, dq_o, dq_oe_n_o;
    logic [15:0] rdata_o;
    logic        dq_line;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // reference model state
    int          t = -1;
    logic [5:0]  addr_q = '0;
    logic [15:0] last_word = '0;

    // memory model state
    int          m_edges = 0;
    logic        m_prev_sk = 1'b0;
    logic [8:0]  m_rx = '0;
    logic [15:0] m_word = '0;
    logic        m_oe = 1'b0;
    logic        m_bit = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // shared line: master buffer wins during overlap, pull-up when nobody drives
    assign dq_line = !dq_oe_n_o ? dq_o : (m_oe ? m_bit : 1'b1);

    mw_read_ctrl #(.DIV(DIV), .HOLD_CYC(HOLD_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .cs_o(cs_o), .sk_o(sk_o), .dq_o(dq_o), .dq_oe_n_o(dq_oe_n_o),
        .dq_i(dq_line));

    function automatic logic [15:0] mem_word(input logic [5:0] a);
        return {a, ~a, a[3:0]} ^ 16'h5A3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // reference model timeline, advanced on each rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            t <= -1;
            last_word <= '0;
        end else if ((t < 0 || t == T_DONE) && start_i) begin
            t <= 0;
            addr_q <= addr_i;
        end else if (t == T_DONE) begin
            t <= -1;
        end else if (t >= 0) begin
            if (t == T_DONE - 1) last_word <= mem_word(addr_q);
            t <= t + 1;
        end
    end

    // memory model and per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            // memory behaviour
            if (!cs_o) begin
                m_edges = 0; m_oe = 1'b0; m_bit = 1'b0;
            end else if (sk_o && !m_prev_sk) begin
                m_edges++;
                if (m_edges <= 9) m_rx = {m_rx[7:0], dq_line};
                if (m_edges == 9) begin
                    chk("R3 frame seen by memory", 32'(m_rx), 32'({3'b110, addr_q}));
                    m_word = mem_word(m_rx[5:0]);
                    m_oe = 1'b1; m_bit = 1'b0;
                end else if (m_edges >= 10 && m_edges <= 25) begin
                    m_bit = m_word[25 - m_edges];
                end
                if (m_edges > 26) chk("R6 rising edges per frame", 32'(m_edges), 32'd26);
            end
            m_prev_sk = sk_o;
            // expected outputs
            if (t < 0) begin
                chk("R6 cs idle", 32'(cs_o), 0);
                chk("R2 sk idle", 32'(sk_o), 0);
                chk("R4 oe_n idle", 32'(dq_oe_n_o), 1);
                chk("R10 busy idle", 32'(busy_o), 0);
                chk("R7 done idle", 32'(done_o), 0);
            end else begin
                chk("R6 cs", 32'(cs_o), 32'(t < T_CSLOW));
                chk("R2 sk", 32'(sk_o), 32'((t < T_CSLOW) && ((t % DIV) >= HALF)));
                chk("R4 oe_n", 32'(dq_oe_n_o), 32'(t >= T_REL));
                chk("R10 busy", 32'(busy_o), 32'(t < T_DONE));
                chk("R7 done", 32'(done_o), 32'(t == T_DONE));
                if (t < T_REL) begin
                    automatic logic [8:0] fr = {3'b110, addr_q};
                    automatic int idx = (t / DIV > 8) ? 8 : t / DIV;
                    chk("R3 dq bit", 32'(dq_o), 32'(fr[8 - idx]));
                end
            end
            chk("R5 rdata", 32'(rdata_o), 32'(last_word));
        end else begin
            m_edges = 0; m_oe = 1'b0; m_prev_sk = 1'b0;
        end
    end

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done_o) return;
        end
        chk("R7 done reached", 0, 1);
    endtask

    task automatic read_word(input logic [5:0] a);
        @(negedge clk);
        start_i = 1'b1; addr_i = a;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk("R5 word", 32'(rdata_o), 32'(mem_word(a)));
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 cs", 32'(cs_o), 0);
        chk("R1 sk", 32'(sk_o), 0);
        chk("R1 oe_n", 32'(dq_oe_n_o), 1);
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 done", 32'(done_o), 0);
        chk("R1 rdata", 32'(rdata_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        read_word(6'h15);
        read_word(6'h3F);
        read_word(6'h00);
        read_word(6'h2A);

        // R8: start requests while busy are ignored
        @(negedge clk); start_i = 1'b1; addr_i = 6'h01;
        @(negedge clk); start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1; addr_i = 6'h3E;
        repeat (5) @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk("R8 word of first address", 32'(rdata_o), 32'(mem_word(6'h01)));

        // R9: address changes after acceptance have no effect
        @(negedge clk); start_i = 1'b1; addr_i = 6'h0C;
        @(negedge clk); start_i = 1'b0; addr_i = 6'h33;
        wait_done();
        chk("R9 word of captured address", 32'(rdata_o), 32'(mem_word(6'h0C)));

        // R7: new start accepted in the done cycle
        @(negedge clk); start_i = 1'b1; addr_i = 6'h07;
        @(negedge clk); start_i = 1'b0;
        wait_done();
        start_i = 1'b1; addr_i = 6'h38;
        @(negedge clk); start_i = 1'b0;
        chk("R7 back-to-back busy", 32'(busy_o), 1);
        wait_done();
        chk("R7 back-to-back word", 32'(rdata_o), 32'(mem_word(6'h38)));

        // R1: reset in the middle of a frame
        @(negedge clk); start_i = 1'b1; addr_i = 6'h10;
        @(negedge clk); start_i = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid cs", 32'(cs_o), 0);
        chk("R1 mid oe_n", 32'(dq_oe_n_o), 1);
        chk("R1 mid busy", 32'(busy_o), 0);
        chk("R1 mid rdata", 32'(rdata_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        read_word(6'h11);

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule